// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block produces the two timing strobes of a multiplexed 8-bit microcontroller memory bus. The first is the address-latch pulse that tells external logic to capture the low address byte. The second is the active-low read strobe for external program memory. It runs on the oscillator clock and counts twelve oscillator periods per machine cycle. That gives two fetch slots per machine cycle. Each slot has an address-latch pulse followed by a read pulse.

Each fetch slot decides whether it goes to on-chip or off-chip program memory. The decision uses an enable level for internal memory and the program counter compared against the top of the on-chip range. A fetch served internally never drives the read strobe. When the CPU marks a machine cycle as an external data access, the bus is lent to the data transfer. In that cycle, the second address-latch pulse and both program read pulses are withheld.

Top module: `bus_strobe_seq`

## Requirements
- R1: After reset the phase counts 0..11 and repeats. `ale` is high in phases 1, 2, 7 and 8, so outside flagged cycles it pulses once every six clocks, two clocks wide.
- R2: `xdata_cycle` is sampled on the clock edge that enters phase 0. When it was 1, the second `ale` pulse of that machine cycle (phases 7 and 8) is withheld and the first is kept.
- R3: For an external fetch, `psen_n` is low in phases 4 and 5, and also in phases 10 and 11. That is two pulses per machine cycle, each two clocks wide.
- R4: In a machine cycle flagged by R2, both `psen_n` pulses are withheld and `psen_n` stays 1.
- R5: A fetch slot served internally (`fetch_ext` = 0) never drives `psen_n` low.
- R6: With `int_rom_en` = 1, a fetch is external only when `pc` is above 0x3FFF. So 0x3FFF is internal and 0x4000 is external.
- R7: With `int_rom_en` = 0, every fetch is external.
- R8: The route decision is sampled on the edges entering phases 4 and 10 and holds until the next such edge. `fetch_ext` shows the decision of the current slot, so changes to `pc` inside a slot have no effect on it.
- R9: `ale` falls before `psen_n` goes low, and the two are never active in the same cycle.
- R10: A synchronous active-high `rst` forces `ale` to 0, `psen_n` to 1, `fetch_ext` to 0 and the phase to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| pc | input | PC_W (16) | Program counter of the next fetch |
| int_rom_en | input | 1 | Level of the pin that allows fetches from on-chip program memory |
| xdata_cycle | input | 1 | The coming machine cycle performs an external data access |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | External program read strobe, active low |
| fetch_ext | output | 1 | Current fetch slot is served by external memory |

## Verification
Assertions check the following on every cycle:
- the phase wrap
- the position and width of the `ale` and `psen_n` pulses
- that the two strobes exclude each other
- the silence of `psen_n` on internal slots
- that the data-access flag holds through the machine cycle

Only the bench scenarios can show the rest:
- which pulses a flagged cycle actually drops
- the 0x3FFF/0x4000 routing boundary under both enable levels
- that `pc` changes inside a slot are ignored
- the restart of the phase after a mid-run reset

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;

    localparam int PHASES_PER_CYCLE = 12;
    localparam int PHASE_W          = $clog2(PHASES_PER_CYCLE);
    localparam int HALF             = PHASES_PER_CYCLE / 2;

    typedef logic [PHASE_W-1:0] phase_t;

    localparam phase_t HALF_P   = phase_t'(HALF);
    localparam phase_t ALE_ON   = phase_t'(1);
    localparam phase_t FETCH_ON = phase_t'(4);

    typedef struct packed {
        logic ale;
        logic psen_n;
        logic fetch_ext;
        logic xd;
    } strobe_regs_t;

    function automatic phase_t slot_offset(phase_t p);
        return (p >= HALF_P) ? phase_t'(p - HALF_P) : p;
    endfunction

    function automatic logic in_second_half(phase_t p);
        return p >= HALF_P;
    endfunction

    function automatic logic ale_window(phase_t p);
        phase_t o;
        o = slot_offset(p);
        return (o == ALE_ON) || (o == phase_t'(ALE_ON + 1'b1));
    endfunction

    function automatic logic read_window(phase_t p);
        phase_t o;
        o = slot_offset(p);
        return (o == FETCH_ON) || (o == phase_t'(FETCH_ON + 1'b1));
    endfunction

    function automatic logic route_sample(phase_t p);
        return slot_offset(p) == FETCH_ON;
    endfunction

endpackage

// File: rtl/strobe_phase_ctr.sv
module strobe_phase_ctr
    import bus_strobe_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_t phase_q,
    output phase_t phase_nxt
);

    localparam phase_t LAST = phase_t'(PHASES_PER_CYCLE - 1);

    phase_t phase_d;

    always_comb begin
        phase_d   = (phase_q == LAST) ? '0 : phase_t'(phase_q + 1'b1);
        phase_nxt = phase_d;
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_d;
    end

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
        phase_q <= LAST);                                     // R1
    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (phase_q == LAST) |=> (phase_q == '0));               // R1

endmodule

// File: rtl/fetch_route.sv
module fetch_route #(
    parameter int              PC_W      = 16,
    parameter logic [PC_W-1:0] INT_LIMIT = PC_W'(16'h3FFF)
) (
    input  logic [PC_W-1:0] pc,
    input  logic            int_rom_en,
    output logic            go_ext
);

    localparam logic [PC_W-1:0] ALL_ONES = {PC_W{1'b1}};

    generate
        if (INT_LIMIT == ALL_ONES) begin : g_full_map
            logic unused_pc;
            assign unused_pc = ^pc;
            always_comb go_ext = !int_rom_en;
        end else begin : g_limited
            always_comb go_ext = !int_rom_en || (pc > INT_LIMIT);
        end
    endgenerate

endmodule

// File: rtl/bus_strobe_seq.sv
module bus_strobe_seq
    import bus_strobe_pkg::*;
#(
    parameter int              PC_W      = 16,
    parameter logic [PC_W-1:0] INT_LIMIT = PC_W'(16'h3FFF)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] pc,
    input  logic            int_rom_en,
    input  logic            xdata_cycle,
    output logic            ale,
    output logic            psen_n,
    output logic            fetch_ext
);

    phase_t       phase_q;
    phase_t       phase_nxt;
    logic         route_ext;
    strobe_regs_t st_d;
    strobe_regs_t st_q;

    strobe_phase_ctr u_phase (
        .clk       (clk),
        .rst       (rst),
        .phase_q   (phase_q),
        .phase_nxt (phase_nxt)
    );

    fetch_route #(
        .PC_W      (PC_W),
        .INT_LIMIT (INT_LIMIT)
    ) u_route (
        .pc         (pc),
        .int_rom_en (int_rom_en),
        .go_ext     (route_ext)
    );

    always_comb begin
        st_d = st_q;
        if (phase_nxt == '0)
            st_d.xd = xdata_cycle;
        if (route_sample(phase_nxt))
            st_d.fetch_ext = route_ext;
        st_d.ale    = ale_window(phase_nxt) &&
                      !(in_second_half(phase_nxt) && st_d.xd);
        st_d.psen_n = !(read_window(phase_nxt) && st_d.fetch_ext && !st_d.xd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{ale: 1'b0, psen_n: 1'b1, fetch_ext: 1'b0, xd: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ale       = st_q.ale;
    assign psen_n    = st_q.psen_n;
    assign fetch_ext = st_q.fetch_ext;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ale && !psen_n));                                           // R9
    AST_ALE_PLACE: assert property (@(posedge clk) disable iff (rst)
        $rose(ale) |-> (phase_q == ALE_ON) ||
                       (phase_q == phase_t'(ALE_ON + HALF_P)));       // R1
    AST_ALE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(ale) |=> ale);                                          // R1
    AST_PSEN_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(psen_n) |=> !psen_n);                                   // R3
    AST_INT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !fetch_ext |-> psen_n);                                       // R5
    AST_XD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (phase_q != '0) |-> $stable(st_q.xd));                        // R2
    AST_XD_NO_READ: assert property (@(posedge clk) disable iff (rst)
        st_q.xd |-> psen_n);                                          // R4
    AST_EXT_ONLY: assert property (@(posedge clk) disable iff (rst)
        (phase_q == FETCH_ON && !$past(int_rom_en)) |-> fetch_ext);   // R7

endmodule

// File: tb/bus_strobe_seq_tb_top.sv
module bus_strobe_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] pc = 16'h0000;
    logic        int_rom_en = 1'b1;
    logic        xdata_cycle = 1'b0;
    logic        ale;
    logic        psen_n;
    logic        fetch_ext;

    always #2 clk = ~clk;

    bus_strobe_seq dut_i (
        .clk         (clk),
        .rst         (rst),
        .pc          (pc),
        .int_rom_en  (int_rom_en),
        .xdata_cycle (xdata_cycle),
        .ale         (ale),
        .psen_n      (psen_n),
        .fetch_ext   (fetch_ext)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;

    // behavioural reference
    int    ph     = 0;
    bit    m_rst  = 1'b1;
    bit    m_xd   = 1'b0;
    bit    m_fx   = 1'b0;
    bit    e_ale  = 1'b0;
    bit    e_psen = 1'b1;
    string fx_tag = "R6";

    always @(posedge clk) begin
        if (rst) begin
            ph = 0; m_rst = 1; m_xd = 0; m_fx = 0; e_ale = 0; e_psen = 1;
        end else begin
            m_rst = 0;
            ph = (ph + 1) % 12;
            if (ph == 0) m_xd = xdata_cycle;
            if (ph % 6 == 4) begin
                m_fx   = !int_rom_en || (pc > 16'h3FFF);
                fx_tag = int_rom_en ? "R6" : "R7";
            end
            e_ale  = (ph % 6 == 1 || ph % 6 == 2) && !(ph >= 6 && m_xd);
            e_psen = !((ph % 6 == 4 || ph % 6 == 5) && m_fx && !m_xd);
        end
    end

    task automatic check(input logic got, input bit exp, input string tag, input string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s phase=%0d got=%0b expected=%0b", tag, what, ph, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check(ale, e_ale,
                  m_rst ? "R10" : ((m_xd && ph >= 6) ? "R2" : "R1"), "ale");
            check(psen_n, e_psen,
                  m_rst ? "R10" : (!m_fx ? "R5" : (m_xd ? "R4" : "R3")), "psen_n");
            check(fetch_ext, m_fx, m_rst ? "R10" : {fx_tag, "_R8"}, "fetch_ext");
            check(ale && !psen_n, 1'b0, "R9", "overlap");
        end
    end

    int unsigned lcg = 32'h1234_5678;
    function automatic int unsigned step(int unsigned s);
        return s * 32'd1103515245 + 32'd12345;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R6 boundary: 0x3FFF internal
        int_rom_en = 1; pc = 16'h3FFF;
        repeat (48) @(negedge clk);
        // R6 boundary: 0x4000 external
        pc = 16'h4000;
        repeat (48) @(negedge clk);
        // R7 external only, low address
        int_rom_en = 0; pc = 16'h0100;
        repeat (48) @(negedge clk);
        // R2 R4 single flagged cycle with external fetches
        xdata_cycle = 1;
        repeat (12) @(negedge clk);
        xdata_cycle = 0;
        repeat (24) @(negedge clk);
        // R8 mixed traffic, pc toggling across the boundary inside slots
        for (int i = 0; i < 400; i++) begin
            lcg = step(lcg);
            xdata_cycle = lcg[20];
            int_rom_en  = lcg[22] | lcg[23];
            pc          = lcg[24] ? 16'h3FFF : 16'h4000;
            @(negedge clk);
        end
        // R10 reset mid run
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0; int_rom_en = 0; xdata_cycle = 0;
        repeat (60) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule